// File: doc/BRIEF.md
# Single-Step Multiplicative Significand Divider

This block produces the quotient significand of a double-precision divide from a normalized numerator, a normalized denominator and a reciprocal seed. The seed must already be accurate to 29 bits, and it comes from a separate seed unit. The block runs a single fused correction step. It forms the scaled numerator `G = R·N` and the residual `V = 1 − R·D`, then returns `Q = G + G·V`. This gives the same result as one round of the multiplicative recurrence that scales numerator and denominator by `R` and then refines `R` to `2 − D`.

The residual is known to be below 2^-29 in magnitude, so every bit of `R·D` above that weight is fixed. Only the low 54 bits of the residual are negated. Its magnitude is cut to a 28-bit field, so the correction needs only a 57×28 multiply. The sign of the residual selects addition or subtraction of the correction. The unit is fully pipelined: it accepts one operand set per cycle, and a valid flag and a caller tag move with each item through every stage. Exponent handling, final rounding and exceptions are done outside the block.

Top module: `gsd_sig_div`

## Requirements
- R1: While `rst_ni` is low, and afterwards until a valid input reaches the output, `valid_o` is 0.
- R2: Each cycle with `valid_i` high gives exactly one cycle with `valid_o` high, `LATENCY` (default 22) cycles later. Operand sets may arrive on consecutive cycles.
- R3: `tag_o` on a valid output equals the `tag_i` that was sampled with the matching input.
- R4: Input formats: `num_i` and `den_i` are unsigned with 1 integer bit and 52 fraction bits, and bit 52 is set. `seed_i` has 1 integer bit and 30 fraction bits, with value at most 1.0. `quo_o` has 1 integer bit and 56 fraction bits. Given a seed with |1 − seed·den| < 2^-29, `quo_o` differs from num/den by at most 2^-54 (4 units of its LSB).
- R5: R4 holds whether the seed is below 1/den (residual non-negative, correction added) or above it (residual negative, correction subtracted).
- R6: If `den_i` is exactly 1.0 and `seed_i` is exactly 1.0, then `quo_o` equals `num_i` shifted left by 4, exactly.
- R7: A cycle with `valid_i` low produces no output. It does not disturb results in flight on either side of it.
- R8: Every valid `quo_o` lies in [0.5, 2), so bit 56 or bit 55 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand set present |
| tag_i | input | TAG_W | Caller tag carried with the operands |
| num_i | input | 53 | Numerator significand, 1.52 format |
| den_i | input | 53 | Denominator significand, 1.52 format |
| seed_i | input | 31 | Reciprocal seed, 1.30 format |
| valid_o | output | 1 | Quotient present |
| tag_o | output | TAG_W | Tag of the emerging quotient |
| quo_o | output | 57 | Quotient significand, 1.56 format |

## Verification
The checker checks on every cycle that valid and tag line up with the input exactly `LATENCY` cycles later, that a valid quotient is never outside [0.5, 2), and that the unity-denominator case is reproduced bit-exactly. Numerical accuracy against the true ratio can only be shown by the bench's scenarios. These drive random back-to-back operands with seeds on both sides of the reciprocal (so both the add and the subtract path run), extreme significands, and idle gaps. Each quotient is compared with an exact integer cross-multiplication.

// File: rtl/gsd_pkg.sv
package gsd_pkg;
  localparam int SIG_W  = 53;                 // 1.52 significand
  localparam int SEED_W = 31;                 // 1.30 seed
  localparam int Q_W    = 57;                 // 1.56 quotient / G
  localparam int VM_W   = 28;                 // residual magnitude field
  localparam int PR_W   = SIG_W + SEED_W;     // full product width (84)
  localparam int PR_FR  = (SIG_W - 1) + (SEED_W - 1); // product fraction bits (82)
  localparam int G_LSB  = PR_FR - (Q_W - 1);  // 26
  localparam int RES_W  = 54;                 // live residual bits, |V|<2^-29
  localparam int VM_LSB = PR_FR - (Q_W - 1) - 1; // 25: weight 2^-57
  localparam int CP_W   = Q_W + VM_W;         // correction product width
  localparam int CP_SH  = PR_FR - VM_LSB;     // 57: align to Q LSB
endpackage

// File: rtl/gsd_vform.sv
// Residual magnitude and sign from the low bits of R*D.
module gsd_vform
  import gsd_pkg::*;
(
  input  logic [RES_W-1:0] prod_lo_i,
  output logic             neg_o,
  output logic [VM_W-1:0]  mag_o
);
  logic [RES_W-1:0] res, res_abs;
  always_comb begin
    res     = '0 - prod_lo_i;   // 1 - R*D modulo 2^54
    neg_o   = res[RES_W-1];
    res_abs = neg_o ? ('0 - res) : res;
    mag_o   = res_abs[VM_LSB +: VM_W];
  end
endmodule

// File: rtl/gsd_delay.sv
module gsd_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign vld_o = vld_i;
      assign dat_o = dat_i;
    end else begin : g_line
      logic [DEPTH-1:0]        vld_q;
      logic [DEPTH-1:0][W-1:0] dat_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vld_q <= '0;
        else         vld_q <= {vld_q[DEPTH-2:0], vld_i};
      end
      always_ff @(posedge clk_i) begin
        dat_q[0] <= dat_i;
        for (int i = 1; i < DEPTH; i++) dat_q[i] <= dat_q[i-1];
      end
      assign vld_o = vld_q[DEPTH-1];
      assign dat_o = dat_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/gsd_sig_div.sv
module gsd_sig_div
  import gsd_pkg::*;
#(
  parameter int LATENCY = 22,
  parameter int TAG_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [SIG_W-1:0] num_i,
  input  logic [SIG_W-1:0] den_i,
  input  logic [SEED_W-1:0] seed_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [Q_W-1:0]   quo_o
);
  localparam int CORE = 4;
  localparam int PAD  = LATENCY - CORE;
  localparam int PW   = TAG_W + Q_W;

  // stage 1: both seed products
  logic [PR_W-1:0]  prod_n, prod_d;
  logic             v1;
  logic [TAG_W-1:0] t1;
  logic [Q_W-1:0]   g1;
  logic [RES_W-1:0] pd1;
  assign prod_n = PR_W'(seed_i) * PR_W'(num_i);
  assign prod_d = PR_W'(seed_i) * PR_W'(den_i);

  // stage 2: residual sign / magnitude
  logic             v2, neg2, neg_c;
  logic [TAG_W-1:0] t2;
  logic [Q_W-1:0]   g2;
  logic [VM_W-1:0]  mag2, mag_c;

  // stage 3: reduced correction multiply
  logic             v3, neg3;
  logic [TAG_W-1:0] t3;
  logic [Q_W-1:0]   g3;
  logic [CP_W-1:0]  cprod;
  logic [VM_W-1:0]  corr3;
  assign cprod = CP_W'(g2) * CP_W'(mag2);

  // stage 4: signed merge
  logic             v4;
  logic [TAG_W-1:0] t4;
  logic [Q_W-1:0]   q4;

  gsd_vform u_vform (.prod_lo_i(pd1), .neg_o(neg_c), .mag_o(mag_c));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {v1, v2, v3, v4} <= '0;
    else         {v1, v2, v3, v4} <= {valid_i, v1, v2, v3};
  end

  always_ff @(posedge clk_i) begin
    t1    <= tag_i;
    g1    <= prod_n[G_LSB +: Q_W];
    pd1   <= prod_d[RES_W-1:0];
    t2    <= t1;
    g2    <= g1;
    neg2  <= neg_c;
    mag2  <= mag_c;
    t3    <= t2;
    g3    <= g2;
    neg3  <= neg2;
    corr3 <= VM_W'(cprod >> CP_SH);
    t4    <= t3;
    q4    <= neg3 ? (g3 - Q_W'(corr3)) : (g3 + Q_W'(corr3));
  end

  logic [PW-1:0] pad_o;
  gsd_delay #(.W(PW), .DEPTH(PAD)) u_pad (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (v4),
    .dat_i ({t4, q4}),
    .vld_o (valid_o),
    .dat_o (pad_o)
  );
  assign {tag_o, quo_o} = pad_o;
endmodule

// File: rtl/gsd_sig_div_chk.sv
module gsd_sig_div_chk #(
  parameter int LATENCY = 22,
  parameter int TAG_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [TAG_W-1:0] tag_i,
  input logic [52:0]      num_i,
  input logic [52:0]      den_i,
  input logic [30:0]      seed_i,
  input logic             valid_o,
  input logic [TAG_W-1:0] tag_o,
  input logic [56:0]      quo_o
);
  logic [LATENCY-1:0]             v_sh, u_sh;
  logic [LATENCY-1:0][TAG_W-1:0]  t_sh;
  logic [LATENCY-1:0][56:0]       e_sh;
  logic unity;
  assign unity = (den_i == 53'h10_0000_0000_0000) && (seed_i == 31'h4000_0000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_sh <= '0;
      u_sh <= '0;
    end else begin
      v_sh <= {v_sh[LATENCY-2:0], valid_i};
      u_sh <= {u_sh[LATENCY-2:0], valid_i & unity};
    end
  end
  always_ff @(posedge clk_i) begin
    t_sh <= {t_sh[LATENCY-2:0], tag_i};
    e_sh <= {e_sh[LATENCY-2:0], {num_i, 4'b0}};
  end

  a_r1_idle_in_reset: assert property (@(posedge clk_i) !rst_ni |-> !valid_o);
  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_sh[LATENCY-1]);
  a_r3_tag_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> tag_o == t_sh[LATENCY-1]);
  a_r6_unity_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && u_sh[LATENCY-1]) |-> quo_o == e_sh[LATENCY-1]);
  a_r8_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (quo_o[56] | quo_o[55]));
endmodule

bind gsd_sig_div gsd_sig_div_chk #(.LATENCY(LATENCY), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/sim_gsd_sig_div.sv
module sim_gsd_sig_div;
  localparam int CLK_P = 10;
  localparam int LAT   = 22;
  localparam int TW    = 8;

  logic clk = 0, rst_n = 0, vin = 0;
  logic [TW-1:0] tin = '0;
  logic [52:0] nin = '0, din = '0;
  logic [30:0] sin = '0;
  logic vout;
  logic [TW-1:0] tout;
  logic [56:0] qout;

  int errors = 0, checks = 0, cyc = 0;
  logic [TW-1:0] tag_ctr = '0;

  typedef struct {
    logic [TW-1:0] tag;
    logic [52:0]   n, d;
    int            t0;
    int            kind; // 0 floor seed, 1 ceil seed, 2 unity
  } item_t;
  item_t sb[$];

  gsd_sig_div #(.LATENCY(LAT), .TAG_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .tag_i(tin),
    .num_i(nin), .den_i(din), .seed_i(sin),
    .valid_o(vout), .tag_o(tout), .quo_o(qout));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [52:0] rnd_sig();
    return {1'b1, 20'($urandom), $urandom};
  endfunction

  task automatic drive(input logic [52:0] n, input logic [52:0] d, input int kind);
    logic [127:0] one, r;
    item_t it;
    one = 128'd1 << 82;
    r   = one / d;
    if (kind == 1 && (one % d) != 0) r = r + 1;
    @(negedge clk);
    vin = 1; tin = tag_ctr; nin = n; din = d; sin = 31'(r);
    it.tag = tag_ctr; it.n = n; it.d = d; it.t0 = cyc; it.kind = kind;
    sb.push_back(it);
    tag_ctr++;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      vin = 0; nin = '0; din = '0; sin = '0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && vout) begin
      if (sb.size() == 0) chk(0, "R7 unexpected output", 128'(qout), 0);
      else begin
        item_t it;
        logic [127:0] lhs, rhs, df, tol;
        it = sb.pop_front();
        chk(cyc - it.t0 == LAT, "R2 latency", 128'(cyc - it.t0), 128'(LAT));
        chk(tout == it.tag, "R3 tag", 128'(tout), 128'(it.tag));
        chk(qout[56] | qout[55], "R8 range", 128'(qout), 128'(1) << 55);
        lhs = 128'(qout) * 128'(it.d);
        rhs = 128'(it.n) << 56;
        df  = (lhs > rhs) ? lhs - rhs : rhs - lhs;
        tol = 128'(it.d) << 2;
        if (it.kind == 2)
          chk(qout == {it.n, 4'b0}, "R6 unity exact", 128'(qout), 128'({it.n, 4'b0}));
        else if (it.kind == 1)
          chk(df <= tol, "R5/R4 accuracy ceil seed (subtract path)", lhs, rhs);
        else
          chk(df <= tol, "R4 accuracy floor seed (add path)", lhs, rhs);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    chk(0, "watchdog", 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(vout == 0, "R1 reset idle", 128'(vout), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(vout == 0, "R1 idle after reset", 128'(vout), 0);
    // R4/R5: back-to-back random, both seed sides
    for (int i = 0; i < 200; i++) drive(rnd_sig(), rnd_sig(), i % 2);
    // extremes
    drive({1'b1, 52'hF_FFFF_FFFF_FFFF}, 53'h10_0000_0000_0001, 1);
    drive({1'b1, 52'hF_FFFF_FFFF_FFFF}, 53'h10_0000_0000_0001, 0);
    drive(53'h10_0000_0000_0000, {1'b1, 52'hF_FFFF_FFFF_FFFF}, 0);
    drive(53'h10_0000_0000_0000, {1'b1, 52'hF_FFFF_FFFF_FFFF}, 1);
    drive(53'h18_0000_0000_0000, 53'h18_0000_0000_0000, 0);
    // R6 unity denominator
    drive({1'b1, 52'hF_FFFF_FFFF_FFFF}, 53'h10_0000_0000_0000, 2);
    drive(rnd_sig(), 53'h10_0000_0000_0000, 2);
    // R7 bubbles between items
    for (int i = 0; i < 30; i++) begin
      drive(rnd_sig(), rnd_sig(), i % 2);
      idle(1 + (i % 3));
    end
    idle(LAT + 5);
    chk(sb.size() == 0, "R2/R7 all results returned", 128'(sb.size()), 0);
    chk(vout == 0, "R7 idle output", 128'(vout), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule